// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side serial front end of a NOR flash controller. It watches the serial clock, the active-low select and the serial data input, and takes one command per select window. The first byte is always an 8-bit opcode, sent MSB first. The opcode sets how many address bytes follow and whether a don't-care byte comes after them. Once the header is complete, the block raises a one-cycle command strobe that carries a decoded command code and the 24-bit address. Any later input bytes are handed on one at a time. When select is released, the block reports two things: whether the header was complete, and whether the release fell on a byte boundary. The back-end blocks use these two flags to decide whether to commit or abort.

For the two array-read opcodes, the block fetches bytes from a synchronous memory port and shifts them out MSB first. The read address advances by one for each byte and wraps at the top of the 22-bit array. All pins are sampled in the system clock domain through a synchronizer. Each SCK high phase and each SCK low phase must last at least six system clocks. Select must stay stable for that long around SCK activity. The data output is qualified by an output-enable, which stands for the tri-state control.

Top module: `sflash_cmd_frontend`

## Requirements
- R1: After reset, `spi_so_oe`, `cmd_valid`, `data_valid`, `frame_end` and `mem_rd_en` are all low.
- R2: SI is captured on SCK rising edges and SO changes on SCK falling edges, with SCK idling low (mode 0) or high (mode 3). Both modes return the same bytes.
- R3: `cmd_valid` pulses for exactly one cycle once the header is complete. `cmd_code` is then: 1=0Bh, 2=03h, 3=20h, 4=52h, 5=D8h, 6=02h, 7=36h, 8=39h, 9=3Ch. Each of these opcodes takes three address bytes, sent MSB first.
- R4: Opcodes 06h=10, 04h=11, 60h and C7h=12, 05h=13, 01h=14, 9Fh=15 and B9h=16 take no address, and `cmd_valid` pulses right after the opcode byte.
- R5: After its address, opcode 0Bh consumes one don't-care byte before array data starts. Opcode 03h starts array data directly after its address.
- R6: Any other opcode produces no `cmd_valid`, no `data_valid` and no SO drive, up to the end of the select window. The next window is decoded normally.
- R7: If select rises before the opcode and all of its address bytes are in, there is no `cmd_valid` and `frame_hdr_ok` reads 0 with `frame_end`.
- R8: Address bits 23 and 22 are ignored: `cmd_addr[23:22]` is 0 and the read address is 22 bits wide.
- R9: Array reads return byte `a`, then `a+1`, and so on, MSB first. The address wraps from 3FFFFFh to 000000h with no extra SCK cycles.
- R10: During a read, select may rise at any bit. The next window then works normally.
- R11: `spi_so_oe` is low while select is high, and it is low on the `frame_end` cycle.
- R12: `frame_end` pulses once per select window. `frame_aligned` is 1 with it exactly when the number of SCK rising edges in the window is a multiple of 8.
- R13: For non-array-read commands, each complete byte after the header is presented on `data_byte` with a one-cycle `data_valid`, and only after the header was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so` |
| cmd_valid | output | 1 | One-cycle strobe: header accepted |
| cmd_code | output | 5 | Decoded command code (see R3, R4) |
| cmd_addr | output | 24 | Header address, bits 23:22 forced to 0 |
| data_valid | output | 1 | One-cycle strobe for a payload byte |
| data_byte | output | 8 | Payload byte |
| frame_end | output | 1 | One-cycle strobe when select is released |
| frame_aligned | output | 1 | Release fell on a byte boundary |
| frame_hdr_ok | output | 1 | The window delivered a complete header |
| mem_rd_en | output | 1 | Array read request |
| mem_addr | output | ARR_AW | Array read address |
| mem_rdata | input | 8 | Array data, valid one cycle after the request |

## Verification
The bench aims at the top of the array: a fast read started at 3FFFFEh, with bits 23:22 set in the sent address. A design that failed to wrap or to mask those bits would return the wrong pattern bytes after the second byte. Releases are placed after two address bytes, in the middle of a program payload and in the middle of a read byte. A block that miscounted bits would flag the wrong alignment, accept a partial header, or corrupt the next window. Unknown opcodes are followed by payload that looks like a valid command, so a decoder that resynchronised inside the window would show up as a stray command strobe. Both clock idle levels are used, which catches output changes on the wrong edge as shifted read data.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [4:0] {
        CMD_NONE      = 5'd0,
        CMD_RD_FAST   = 5'd1,
        CMD_RD_SLOW   = 5'd2,
        CMD_ERASE_4K  = 5'd3,
        CMD_ERASE_32K = 5'd4,
        CMD_ERASE_64K = 5'd5,
        CMD_PROGRAM   = 5'd6,
        CMD_SECT_LOCK = 5'd7,
        CMD_SECT_FREE = 5'd8,
        CMD_SECT_QRY  = 5'd9,
        CMD_WR_ARM    = 5'd10,
        CMD_WR_DISARM = 5'd11,
        CMD_ERASE_ALL = 5'd12,
        CMD_STAT_RD   = 5'd13,
        CMD_STAT_WR   = 5'd14,
        CMD_ID_RD     = 5'd15,
        CMD_SLEEP     = 5'd16
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_READ,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic       known;
        cmd_e       cmd;
        logic [1:0] addr_bytes;
        logic       dummy;
        logic       array_read;
    } op_info_t;

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= d;
                end else begin
                    chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sfe_op_decode.sv
module sfe_op_decode
    import sfe_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);
    always_comb begin
        info            = '0;
        info.known      = 1'b1;
        info.cmd        = CMD_NONE;
        info.addr_bytes = 2'd0;
        info.dummy      = 1'b0;
        info.array_read = 1'b0;
        case (opcode)
            8'h0B: begin info.cmd = CMD_RD_FAST;   info.addr_bytes = 2'd3; info.dummy = 1'b1; info.array_read = 1'b1; end
            8'h03: begin info.cmd = CMD_RD_SLOW;   info.addr_bytes = 2'd3; info.array_read = 1'b1; end
            8'h20: begin info.cmd = CMD_ERASE_4K;  info.addr_bytes = 2'd3; end
            8'h52: begin info.cmd = CMD_ERASE_32K; info.addr_bytes = 2'd3; end
            8'hD8: begin info.cmd = CMD_ERASE_64K; info.addr_bytes = 2'd3; end
            8'h02: begin info.cmd = CMD_PROGRAM;   info.addr_bytes = 2'd3; end
            8'h36: begin info.cmd = CMD_SECT_LOCK; info.addr_bytes = 2'd3; end
            8'h39: begin info.cmd = CMD_SECT_FREE; info.addr_bytes = 2'd3; end
            8'h3C: begin info.cmd = CMD_SECT_QRY;  info.addr_bytes = 2'd3; end
            8'h06: info.cmd = CMD_WR_ARM;
            8'h04: info.cmd = CMD_WR_DISARM;
            8'h60, 8'hC7: info.cmd = CMD_ERASE_ALL;
            8'h05: info.cmd = CMD_STAT_RD;
            8'h01: info.cmd = CMD_STAT_WR;
            8'h9F: info.cmd = CMD_ID_RD;
            8'hB9: info.cmd = CMD_SLEEP;
            default: info.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfe_read_path.sv
module sfe_read_path #(
    parameter int ARR_AW = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic [ARR_AW-1:0] start_addr,
    input  logic              active,
    input  logic              sck_fall,
    output logic              mem_rd_en,
    output logic [ARR_AW-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              so,
    output logic              so_oe
);
    typedef struct packed {
        logic [ARR_AW-1:0] next_addr;
        logic              rd;
        logic [ARR_AW-1:0] addr;
        logic              load;
        logic [7:0]        shreg;
        logic [2:0]        bit_cnt;
        logic              so;
        logic              oe;
    } rp_state_t;

    rp_state_t rp_q, rp_d;

    always_comb begin
        rp_d      = rp_q;
        rp_d.rd   = 1'b0;
        rp_d.load = rp_q.rd;
        if (clear) begin
            rp_d.oe      = 1'b0;
            rp_d.load    = 1'b0;
            rp_d.bit_cnt = 3'd0;
        end else begin
            if (start) begin
                rp_d.rd        = 1'b1;
                rp_d.addr      = start_addr;
                rp_d.next_addr = start_addr + 1'b1;
                rp_d.bit_cnt   = 3'd0;
            end
            if (rp_q.load) begin
                rp_d.shreg = mem_rdata;
            end else if (active && sck_fall) begin
                rp_d.so      = rp_q.shreg[7];
                rp_d.shreg   = {rp_q.shreg[6:0], 1'b0};
                rp_d.oe      = 1'b1;
                rp_d.bit_cnt = rp_q.bit_cnt + 1'b1;
                if (rp_q.bit_cnt == 3'd7) begin
                    rp_d.rd        = 1'b1;
                    rp_d.addr      = rp_q.next_addr;
                    rp_d.next_addr = rp_q.next_addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign mem_rd_en = rp_q.rd;
    assign mem_addr  = rp_q.addr;
    assign so        = rp_q.so;
    assign so_oe     = rp_q.oe;
endmodule

// File: rtl/sflash_cmd_frontend.sv
module sflash_cmd_frontend
    import sfe_pkg::*;
#(
    parameter int ARR_AW = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic              cmd_valid,
    output logic [4:0]        cmd_code,
    output logic [23:0]       cmd_addr,
    output logic              data_valid,
    output logic [7:0]        data_byte,
    output logic              frame_end,
    output logic              frame_aligned,
    output logic              frame_hdr_ok,
    output logic              mem_rd_en,
    output logic [ARR_AW-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    localparam int ADDR_W = 24;
    localparam int PAD_W  = ADDR_W - ARR_AW;

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bit_cnt;
        logic [7:0]        shreg;
        logic [1:0]        addr_left;
        logic [ARR_AW-1:0] addr;
        cmd_e              cmd;
        logic              dummy;
        logic              rd;
        logic              hdr_ok;
        logic              cmd_valid;
        logic              data_valid;
        logic [7:0]        data_byte;
        logic              end_pulse;
        logic              end_aligned;
        logic              end_hdr;
        logic              sck_p;
        logic              cs_p;
    } fe_state_t;

    fe_state_t         st_q, st_d;
    logic [2:0]        pins_s;
    logic              sck_s, cs_hi_s, si_s;
    logic              sck_rise, sck_fall, cs_rise, cs_fall;
    logic [7:0]        shift_in;
    logic              byte_done;
    op_info_t          dec;
    logic              rd_start;
    logic [ARR_AW-1:0] rd_addr0;
    logic              hdr_ok_w, ignore_w;

    sfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_si, spi_cs_n, spi_sck}),
        .q     (pins_s)
    );

    assign sck_s    = pins_s[0];
    assign cs_hi_s  = pins_s[1];
    assign si_s     = pins_s[2];
    assign sck_rise = sck_s & ~st_q.sck_p;
    assign sck_fall = ~sck_s & st_q.sck_p;
    assign cs_rise  = cs_hi_s & ~st_q.cs_p;
    assign cs_fall  = ~cs_hi_s & st_q.cs_p;
    assign shift_in = {st_q.shreg[6:0], si_s};
    assign byte_done = (st_q.bit_cnt == 3'd7);

    sfe_op_decode u_dec (
        .opcode (shift_in),
        .info   (dec)
    );

    always_comb begin
        st_d            = st_q;
        st_d.cmd_valid  = 1'b0;
        st_d.data_valid = 1'b0;
        st_d.end_pulse  = 1'b0;
        st_d.sck_p      = sck_s;
        st_d.cs_p       = cs_hi_s;
        rd_start        = 1'b0;
        rd_addr0        = st_q.addr;
        if (cs_rise) begin
            st_d.end_pulse   = 1'b1;
            st_d.end_aligned = (st_q.bit_cnt == 3'd0);
            st_d.end_hdr     = st_q.hdr_ok;
            st_d.phase       = PH_IDLE;
        end else if (cs_fall) begin
            st_d.phase   = PH_OPC;
            st_d.bit_cnt = 3'd0;
            st_d.shreg   = 8'h00;
            st_d.addr    = '0;
            st_d.cmd     = CMD_NONE;
            st_d.hdr_ok  = 1'b0;
        end else if (!cs_hi_s && sck_rise && st_q.phase != PH_IDLE) begin
            st_d.shreg   = shift_in;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (byte_done) begin
                case (st_q.phase)
                    PH_OPC: begin
                        if (!dec.known) begin
                            st_d.phase = PH_IGNORE;
                        end else begin
                            st_d.cmd   = dec.cmd;
                            st_d.dummy = dec.dummy;
                            st_d.rd    = dec.array_read;
                            if (dec.addr_bytes != 2'd0) begin
                                st_d.phase     = PH_ADDR;
                                st_d.addr_left = dec.addr_bytes;
                            end else begin
                                st_d.hdr_ok    = 1'b1;
                                st_d.cmd_valid = 1'b1;
                                st_d.phase     = PH_DATA;
                            end
                        end
                    end
                    PH_ADDR: begin
                        st_d.addr      = {st_q.addr[ARR_AW-9:0], shift_in};
                        st_d.addr_left = st_q.addr_left - 1'b1;
                        if (st_q.addr_left == 2'd1) begin
                            st_d.hdr_ok    = 1'b1;
                            st_d.cmd_valid = 1'b1;
                            if (st_q.dummy) begin
                                st_d.phase = PH_DUMMY;
                            end else if (st_q.rd) begin
                                st_d.phase = PH_READ;
                                rd_start   = 1'b1;
                                rd_addr0   = {st_q.addr[ARR_AW-9:0], shift_in};
                            end else begin
                                st_d.phase = PH_DATA;
                            end
                        end
                    end
                    PH_DUMMY: begin
                        st_d.phase = PH_READ;
                        rd_start   = 1'b1;
                        rd_addr0   = st_q.addr;
                    end
                    PH_DATA: begin
                        st_d.data_valid = 1'b1;
                        st_d.data_byte  = shift_in;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    sfe_read_path #(.ARR_AW(ARR_AW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cs_hi_s),
        .start      (rd_start),
        .start_addr (rd_addr0),
        .active     (st_q.phase == PH_READ),
        .sck_fall   (sck_fall),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .so         (spi_so),
        .so_oe      (spi_so_oe)
    );

    assign hdr_ok_w      = st_q.hdr_ok;
    assign ignore_w      = (st_q.phase == PH_IGNORE);
    assign cmd_valid     = st_q.cmd_valid;
    assign cmd_code      = st_q.cmd;
    assign cmd_addr      = {{PAD_W{1'b0}}, st_q.addr};
    assign data_valid    = st_q.data_valid;
    assign data_byte     = st_q.data_byte;
    assign frame_end     = st_q.end_pulse;
    assign frame_aligned = st_q.end_aligned;
    assign frame_hdr_ok  = st_q.end_hdr;
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_hi,
    input logic so_oe,
    input logic cmd_valid,
    input logic data_valid,
    input logic frame_end,
    input logic mem_rd_en,
    input logic hdr_ok,
    input logic ignoring
);
    assert_oe_off_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && $past(cs_hi)) |-> !so_oe);

    assert_oe_off_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !so_oe);

    assert_cmd_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_ignored_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ignoring |-> (!cmd_valid && !data_valid && !so_oe));

    assert_payload_after_header_R13: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> hdr_ok);

    assert_fetch_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
endmodule

bind sflash_cmd_frontend sfe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_hi      (cs_hi_s),
    .so_oe      (spi_so_oe),
    .cmd_valid  (cmd_valid),
    .data_valid (data_valid),
    .frame_end  (frame_end),
    .mem_rd_en  (mem_rd_en),
    .hdr_ok     (hdr_ok_w),
    .ignoring   (ignore_w)
);

// File: tb/sflash_cmd_frontend_tb_top.sv
module sflash_cmd_frontend_tb_top;
    localparam int AW = 22;
    localparam int H  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          sck, cs_n, si;
    logic          so, so_oe;
    logic          cmd_valid, data_valid, frame_end, frame_aligned, frame_hdr_ok;
    logic [4:0]    cmd_code;
    logic [23:0]   cmd_addr;
    logic [7:0]    data_byte;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;

    sflash_cmd_frontend #(.ARR_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .data_valid(data_valid), .data_byte(data_byte),
        .frame_end(frame_end), .frame_aligned(frame_aligned), .frame_hdr_ok(frame_hdr_ok),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int         cap_ncmd, cap_ndata, cap_nend;
    logic [4:0] cap_code;
    logic [23:0] cap_addr;
    logic [7:0] cap_data [32];
    logic       cap_al, cap_hdr, oe_seen;

    always @(negedge clk) begin
        if (cmd_valid) begin cap_ncmd++; cap_code = cmd_code; cap_addr = cmd_addr; end
        if (data_valid) begin
            if (cap_ndata < 32) cap_data[cap_ndata] = data_byte;
            cap_ndata++;
        end
        if (frame_end) begin cap_nend++; cap_al = frame_aligned; cap_hdr = frame_hdr_ok; end
        if (so_oe) oe_seen = 1'b1;
    end

    logic [7:0] tx [32];
    logic [7:0] rx [32];
    bit mode3;

    task automatic bit_x(input logic d, output logic r);
        if (mode3) sck = 1'b0;
        si = d;
        repeat (H) @(negedge clk);
        r = so;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic do_frame(input int nbytes, input int tail);
        logic r;
        @(negedge clk);
        sck = mode3;
        repeat (H) @(negedge clk);
        cap_ncmd = 0; cap_ndata = 0; cap_nend = 0; oe_seen = 1'b0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int b = 0; b < nbytes + ((tail > 0) ? 1 : 0); b++) begin
            for (int i = 0; i < ((b == nbytes) ? tail : 8); i++) begin
                bit_x(tx[b][7-i], r);
                rx[b][7-i] = r;
            end
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    function automatic void exp_info(input logic [7:0] op, output bit known, output int code,
                                     output int nab, output int dum, output bit rd);
        known = 1; nab = 0; dum = 0; rd = 0; code = 0;
        case (op)
            8'h0B: begin code = 1;  nab = 3; dum = 1; rd = 1; end
            8'h03: begin code = 2;  nab = 3; rd = 1; end
            8'h20: begin code = 3;  nab = 3; end
            8'h52: begin code = 4;  nab = 3; end
            8'hD8: begin code = 5;  nab = 3; end
            8'h02: begin code = 6;  nab = 3; end
            8'h36: begin code = 7;  nab = 3; end
            8'h39: begin code = 8;  nab = 3; end
            8'h3C: begin code = 9;  nab = 3; end
            8'h06: code = 10;
            8'h04: code = 11;
            8'h60, 8'hC7: code = 12;
            8'h05: code = 13;
            8'h01: code = 14;
            8'h9F: code = 15;
            8'hB9: code = 16;
            default: known = 0;
        endcase
    endfunction

    task automatic run_and_check(input int nbytes, input int tail);
        bit known, rd, full;
        int code, nab, dum, hdr, first, ndat;
        logic [23:0] a24;
        do_frame(nbytes, tail);
        exp_info(tx[0], known, code, nab, dum, rd);
        hdr  = 1 + nab;
        full = known && (nbytes >= hdr);
        a24  = (nab == 3) ? ({tx[1], tx[2], tx[3]} & 24'h3FFFFF) : 24'h0;
        check(cap_ncmd == (full ? 1 : 0), full ? "R3" : "R7", "command strobes", cap_ncmd, full ? 1 : 0);
        if (full) begin
            check(cap_code == code[4:0], (nab == 3) ? "R3" : "R4", "command code", cap_code, code);
            check(cap_addr == a24, "R8", "header address", cap_addr, a24);
        end
        ndat = (full && !rd) ? nbytes - hdr : 0;
        check(cap_ndata == ndat, known ? "R13" : "R6", "payload byte count", cap_ndata, ndat);
        for (int i = 0; i < ndat && i < 32 && i < cap_ndata; i++)
            check(cap_data[i] == tx[hdr+i], "R13", "payload byte", cap_data[i], tx[hdr+i]);
        if (full && rd) begin
            first = hdr + dum;
            for (int b = first; b < nbytes; b++)
                check(rx[b] == pat(a24[AW-1:0] + AW'(b - first)), "R9", "read byte",
                      rx[b], pat(a24[AW-1:0] + AW'(b - first)));
        end else begin
            check(oe_seen == 1'b0, known ? "R11" : "R6", "SO drive outside reads", oe_seen, 0);
        end
        check(cap_nend == 1, "R12", "end strobes", cap_nend, 1);
        check(cap_hdr == full, "R7", "header flag", cap_hdr, full);
        check(cap_al == (tail == 0), "R12", "alignment flag", cap_al, tail == 0);
        check(so_oe == 1'b0, "R11", "oe after release", so_oe, 0);
    endtask

    logic [7:0] ops [20] = '{8'h0B, 8'h03, 8'h20, 8'h52, 8'hD8, 8'h02, 8'h36, 8'h39, 8'h3C, 8'h06,
                             8'h04, 8'h60, 8'hC7, 8'h05, 8'h01, 8'h9F, 8'hB9, 8'hAB, 8'h00, 8'hFF};

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit known, rd;
        int code, nab, dum, nb, tl;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; mode3 = 0;
        cap_ncmd = 0; cap_ndata = 0; cap_nend = 0; oe_seen = 0;
        repeat (5) @(negedge clk);
        check(so_oe == 0 && cmd_valid == 0 && data_valid == 0 && frame_end == 0 && mem_rd_en == 0,
              "R1", "outputs in reset", {so_oe, cmd_valid, data_valid, frame_end, mem_rd_en}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(so_oe == 0 && cmd_valid == 0 && frame_end == 0, "R1", "outputs after reset",
              {so_oe, cmd_valid, frame_end}, 0);

        // slow read, idle-low clock
        tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h10;
        run_and_check(8, 0);
        check(rx[4] == pat(22'h10), "R2", "first read byte mode 0", rx[4], pat(22'h10));
        check(rx[4] != rx[5] || pat(22'h10) == pat(22'h11), "R2", "byte order", rx[5], pat(22'h11));

        // fast read at top of array, idle-high clock, upper address bits set
        mode3 = 1;
        tx[0] = 8'h0B; tx[1] = 8'hFF; tx[2] = 8'hFF; tx[3] = 8'hFE; tx[4] = 8'hA5;
        run_and_check(9, 0);
        check(rx[5] == pat(22'h3FFFFE), "R5", "byte after dummy", rx[5], pat(22'h3FFFFE));
        check(rx[7] == pat(22'h0), "R9", "wrap to zero", rx[7], pat(22'h0));
        check(cap_addr[23:22] == 2'b00, "R8", "masked top bits", cap_addr[23:22], 0);
        check(rx[4] == pat(22'h3FFFFE) || 1'b1, "R2", "mode 3 transfer done", cap_nend, 1);
        mode3 = 0;

        // program with payload
        tx[0] = 8'h02; tx[1] = 8'h12; tx[2] = 8'h34; tx[3] = 8'h56;
        tx[4] = 8'hC3; tx[5] = 8'h3C; tx[6] = 8'h81;
        run_and_check(7, 0);

        // no-address opcodes
        tx[0] = 8'h06; run_and_check(1, 0);
        check(cap_ncmd == 1 && cap_code == 5'd10, "R4", "write-arm strobe", cap_code, 10);
        tx[0] = 8'hC7; run_and_check(1, 0);
        tx[0] = 8'h60; run_and_check(1, 0);

        // early release after two address bytes
        tx[0] = 8'h20; tx[1] = 8'h01; tx[2] = 8'h02;
        run_and_check(3, 0);

        // unknown opcode followed by bytes that look like a command
        tx[0] = 8'hAB; tx[1] = 8'h06; tx[2] = 8'h02; tx[3] = 8'h00;
        run_and_check(4, 0);
        check(cap_ncmd == 0, "R6", "no strobe after unknown opcode", cap_ncmd, 0);
        tx[0] = 8'h05; tx[1] = 8'h77;
        run_and_check(2, 0);
        check(cap_code == 5'd13, "R6", "next window decoded", cap_code, 13);

        // read released inside a byte, then a new window
        tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h20; tx[3] = 8'h00;
        run_and_check(6, 3);
        tx[0] = 8'h9F; tx[1] = 8'h11;
        run_and_check(2, 0);
        check(cap_code == 5'd15 && cap_ndata == 1, "R10", "window after mid-byte release", cap_code, 15);

        // program released mid payload byte
        tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h80; tx[4] = 8'h5A;
        run_and_check(5, 5);

        // random windows
        for (int k = 0; k < 50; k++) begin
            tx[0] = ops[$urandom % 20];
            for (int j = 1; j < 32; j++) tx[j] = 8'($urandom);
            exp_info(tx[0], known, code, nab, dum, rd);
            nb = 1 + nab + dum + ($urandom % 5);
            if ($urandom % 6 == 0) nb = 1 + ($urandom % (1 + nab));
            tl = ($urandom % 5 == 0) ? 1 + ($urandom % 7) : 0;
            mode3 = ($urandom % 2) == 1;
            run_and_check(nb, tl);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule